// File: doc/BRIEF.md
# Power Management Reset Policy Controller

This block turns one small software-visible policy word into the reset and power-down behaviour of a platform. Software writes the word over a single-register write port and can always read it back. The controller then applies the word to five kinds of event. A shutdown message becomes either a processor INIT pulse or a platform reset pulse. A two-stage watchdog first asks for a system management interrupt and then for a reboot. A pin strap can permanently block that reboot. A sleep-entry request is supervised by an optional hang timer. When the CPU power-good signal drops, the PLL enable is held for a selectable minimum time before it is released.

All timing runs from a one-microsecond tick input. The controller uses a single clock and a synchronous active-high reset. Each output is a registered signal, so downstream reset logic can take it directly.

Top module: `pmrp_ctrl`

## Requirements
- R1: After reset the read word is 0. Bits 31:6 and bit 2 always read 0, whatever is written. Writing all ones with the strap lock clear reads back 0x0000003B.
- R2: The shutdown-to-reset bit is bit 5. While it is 0, a shutdown message drives `init_o` high for exactly PULSE_W (default 16) clocks, starting the cycle after the message.
- R3: While bit 5 is 1, a shutdown message drives `plat_rst_o` high for exactly PULSE_W clocks. Bit 5 reads 0 once `plat_rst_o` has been high.
- R4: The no-reboot bit is bit 4. It takes the value of `noreboot_strap` on each rising edge of `core_pwrok`.
- R5: If the strap was sampled high, writes cannot clear bit 4. If it was sampled low, software can set and clear bit 4.
- R6: The watchdog expires every WDT_TICKS ticks unless it is kicked. The first expiry pulses `smi_o`. The next expiry pulses `reboot_o`, unless bit 4 is set. A kick reloads the counter and forgets any earlier expiry.
- R7: The sleep-timeout enable is bit 3. When bit 3 is 1 and `sleep_done` has not arrived within SLEEP_TO_US ticks after `sleep_req`, `s5_rst_o` pulses. If `sleep_done` arrives first, or bit 3 is 0, there is no pulse.
- R8: `pll_en_o` rises with `cpu_pwrgood`. After `cpu_pwrgood` falls, `pll_en_o` stays high for the number of ticks that bits 1:0 select: 00 = 10, 01 = 100, 10 = 1000, 11 = 10000.
- R9: The delay code is captured when `cpu_pwrgood` falls. A write during the countdown does not change the delay already running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_us | input | 1 | One-cycle pulse every microsecond |
| reg_wr | input | 1 | Write strobe for the policy word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Current policy word |
| core_pwrok | input | 1 | Core power good; its rising edge samples the strap |
| noreboot_strap | input | 1 | No-reboot strap level |
| shutdown_msg | input | 1 | One-cycle shutdown message |
| wdt_kick | input | 1 | Watchdog reload pulse |
| sleep_req | input | 1 | One-cycle sleep-entry start |
| sleep_done | input | 1 | Sleep-entry flow completed |
| cpu_pwrgood | input | 1 | CPU power good |
| init_o | output | 1 | Processor INIT pulse |
| plat_rst_o | output | 1 | Platform reset pulse |
| smi_o | output | 1 | Watchdog first-expiry interrupt request |
| reboot_o | output | 1 | Watchdog reboot request |
| s5_rst_o | output | 1 | Direct-to-S5 global reset request |
| pll_en_o | output | 1 | PLL enable |

## Verification
Some behaviours are checked by assertions on every cycle:
- Reserved bits always read zero.
- An INIT pulse rises only after a shutdown message seen with bit 5 clear.
- Bit 5 clears after a platform reset.
- A locked strap keeps bit 4 set.
- A reboot and an S5 reset are issued only under the policy bits that allow them.
- PLL enable is high whenever power good was high on the previous cycle.

The rest can only be shown by the bench's scenarios:
- The exact pulse widths.
- The order of watchdog expiries, and the effect of a kick.
- The effect of an early sleep completion.
- The four measured power-down delays.
- That a delay keeps its value when the code is rewritten mid-countdown.

// File: rtl/pmrp_pkg.sv
package pmrp_pkg;

    localparam int REG_W = 32;
    localparam int DLY_W = 14;

    localparam int CH_INIT = 0;
    localparam int CH_PRST = 1;
    localparam int NCH     = 2;

    typedef enum logic [1:0] {
        PD_10US  = 2'b00,
        PD_100US = 2'b01,
        PD_1MS   = 2'b10,
        PD_10MS  = 2'b11
    } pd_code_t;

    typedef struct packed {
        logic     shut_rst;
        logic     no_reboot;
        logic     sx_to_en;
        pd_code_t pd_dly;
    } policy_t;

    function automatic logic [DLY_W-1:0] pd_ticks(pd_code_t c);
        logic [DLY_W-1:0] t;
        case (c)
            PD_10US:  t = DLY_W'(10);
            PD_100US: t = DLY_W'(100);
            PD_1MS:   t = DLY_W'(1000);
            PD_10MS:  t = DLY_W'(10000);
            default:  t = DLY_W'(10000);
        endcase
        return t;
    endfunction

    function automatic logic [REG_W-1:0] pack_policy(policy_t p);
        return {26'b0, p.shut_rst, p.no_reboot, p.sx_to_en, 1'b0, p.pd_dly};
    endfunction

endpackage

// File: rtl/pmrp_regs.sv
module pmrp_regs
    import pmrp_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    wr_en,
    input  policy_t wr_pol,
    input  logic    pwrok,
    input  logic    strap,
    input  logic    prst_active,
    output policy_t pol,
    output logic    strap_lock
);

    logic pwrok_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pol        <= '0;
            pwrok_q    <= 1'b0;
            strap_lock <= 1'b0;
        end else begin
            pwrok_q <= pwrok;
            if (wr_en) begin
                pol.shut_rst  <= wr_pol.shut_rst;
                pol.no_reboot <= wr_pol.no_reboot | strap_lock;
                pol.sx_to_en  <= wr_pol.sx_to_en;
                pol.pd_dly    <= wr_pol.pd_dly;
            end
            if (pwrok && !pwrok_q) begin
                pol.no_reboot <= strap;
                strap_lock    <= strap;
            end
            if (prst_active) begin
                pol.shut_rst <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/pmrp_wdt.sv
module pmrp_wdt #(
    parameter int unsigned TICKS = 4096
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic kick,
    input  logic no_reboot,
    output logic smi,
    output logic reboot
);

    localparam int CW = $clog2(TICKS + 1);
    localparam logic [CW-1:0] LOAD = CW'(TICKS);

    logic [CW-1:0] cnt;
    logic          armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= LOAD;
            armed  <= 1'b0;
            smi    <= 1'b0;
            reboot <= 1'b0;
        end else begin
            smi    <= 1'b0;
            reboot <= 1'b0;
            if (kick) begin
                cnt   <= LOAD;
                armed <= 1'b0;
            end else if (tick) begin
                if (cnt <= CW'(1)) begin
                    cnt <= LOAD;
                    if (armed) begin
                        armed  <= 1'b0;
                        reboot <= !no_reboot;
                    end else begin
                        armed <= 1'b1;
                        smi   <= 1'b1;
                    end
                end else begin
                    cnt <= cnt - CW'(1);
                end
            end
        end
    end

endmodule

// File: rtl/pmrp_sleep_sup.sv
module pmrp_sleep_sup #(
    parameter int unsigned TO_US = 16000
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic req,
    input  logic done,
    input  logic enable,
    output logic s5_rst
);

    localparam int CW = $clog2(TO_US + 1);
    localparam logic [CW-1:0] LAST = CW'(TO_US - 1);

    logic [CW-1:0] cnt;
    logic          active;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            active <= 1'b0;
            s5_rst <= 1'b0;
        end else begin
            s5_rst <= 1'b0;
            if (done) begin
                active <= 1'b0;
            end else if (req) begin
                active <= 1'b1;
                cnt    <= '0;
            end else if (active && tick) begin
                if (cnt == LAST) begin
                    active <= 1'b0;
                    s5_rst <= enable;
                end else begin
                    cnt <= cnt + CW'(1);
                end
            end
        end
    end

endmodule

// File: rtl/pmrp_pll_seq.sv
module pmrp_pll_seq
    import pmrp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     pwrgood,
    input  pd_code_t code,
    output logic     pll_en
);

    logic             pg_q;
    logic             running;
    logic [DLY_W-1:0] cnt;
    logic [DLY_W-1:0] limit;

    always_ff @(posedge clk) begin
        if (rst) begin
            pg_q    <= 1'b0;
            running <= 1'b0;
            cnt     <= '0;
            limit   <= '0;
            pll_en  <= 1'b0;
        end else begin
            pg_q <= pwrgood;
            if (pwrgood) begin
                pll_en  <= 1'b1;
                running <= 1'b0;
            end else if (pg_q) begin
                running <= 1'b1;
                cnt     <= '0;
                limit   <= pd_ticks(code);
            end else if (running && tick) begin
                if (cnt == limit - DLY_W'(1)) begin
                    pll_en  <= 1'b0;
                    running <= 1'b0;
                end else begin
                    cnt <= cnt + DLY_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/pmrp_stretch.sv
module pmrp_stretch #(
    parameter int unsigned W = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    output logic pulse
);

    localparam int CW = $clog2(W + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            pulse <= 1'b0;
        end else if (trig) begin
            cnt   <= CW'(W - 1);
            pulse <= 1'b1;
        end else if (cnt != '0) begin
            cnt <= cnt - CW'(1);
        end else begin
            pulse <= 1'b0;
        end
    end

endmodule

// File: rtl/pmrp_ctrl.sv
module pmrp_ctrl
    import pmrp_pkg::*;
#(
    parameter int unsigned WDT_TICKS   = 4096,
    parameter int unsigned SLEEP_TO_US = 16000,
    parameter int unsigned PULSE_W     = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_us,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              core_pwrok,
    input  logic              noreboot_strap,
    input  logic              shutdown_msg,
    input  logic              wdt_kick,
    input  logic              sleep_req,
    input  logic              sleep_done,
    input  logic              cpu_pwrgood,
    output logic              init_o,
    output logic              plat_rst_o,
    output logic              smi_o,
    output logic              reboot_o,
    output logic              s5_rst_o,
    output logic              pll_en_o
);

    policy_t          pol;
    policy_t          wr_pol;
    logic             strap_lock;
    logic [NCH-1:0]   trig;
    logic [NCH-1:0]   pulse;

    always_comb begin
        wr_pol.shut_rst  = reg_wdata[5];
        wr_pol.no_reboot = reg_wdata[4];
        wr_pol.sx_to_en  = reg_wdata[3];
        wr_pol.pd_dly    = pd_code_t'(reg_wdata[1:0]);
    end

    pmrp_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (reg_wr),
        .wr_pol      (wr_pol),
        .pwrok       (core_pwrok),
        .strap       (noreboot_strap),
        .prst_active (pulse[CH_PRST]),
        .pol         (pol),
        .strap_lock  (strap_lock)
    );

    assign reg_rdata = pack_policy(pol);

    assign trig[CH_INIT] = shutdown_msg & ~pol.shut_rst;
    assign trig[CH_PRST] = shutdown_msg &  pol.shut_rst;

    for (genvar g = 0; g < NCH; g++) begin : g_pulse
        pmrp_stretch #(.W(PULSE_W)) u_str (
            .clk   (clk),
            .rst   (rst),
            .trig  (trig[g]),
            .pulse (pulse[g])
        );
    end

    assign init_o     = pulse[CH_INIT];
    assign plat_rst_o = pulse[CH_PRST];

    pmrp_wdt #(.TICKS(WDT_TICKS)) u_wdt (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick_us),
        .kick      (wdt_kick),
        .no_reboot (pol.no_reboot),
        .smi       (smi_o),
        .reboot    (reboot_o)
    );

    pmrp_sleep_sup #(.TO_US(SLEEP_TO_US)) u_sleep (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick_us),
        .req    (sleep_req),
        .done   (sleep_done),
        .enable (pol.sx_to_en),
        .s5_rst (s5_rst_o)
    );

    pmrp_pll_seq u_pll (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick_us),
        .pwrgood (cpu_pwrgood),
        .code    (pol.pd_dly),
        .pll_en  (pll_en_o)
    );

endmodule

// File: rtl/pmrp_chk.sv
module pmrp_chk (
    input logic        clk,
    input logic        rst,
    input logic        reg_wr,
    input logic [31:0] reg_wdata,
    input logic [31:0] reg_rdata,
    input logic        shutdown_msg,
    input logic        init_o,
    input logic        plat_rst_o,
    input logic        reboot_o,
    input logic        s5_rst_o,
    input logic        cpu_pwrgood,
    input logic        pll_en_o,
    input logic        strap_lock
);

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[31:6] == 26'd0 && !reg_rdata[2]); // R1

    AST_RSVD_WR_IGNORED: assert property (@(posedge clk) disable iff (rst)
        reg_wr && (|reg_wdata[31:6] || reg_wdata[2]) |=> reg_rdata[31:6] == 26'd0 && !reg_rdata[2]); // R1

    AST_INIT_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(init_o) |-> $past(shutdown_msg) && !$past(reg_rdata[5])); // R2

    AST_INIT_HELD: assert property (@(posedge clk) disable iff (rst)
        $rose(init_o) |=> init_o); // R2

    AST_SPS_CLEARED: assert property (@(posedge clk) disable iff (rst)
        plat_rst_o |=> !reg_rdata[5]); // R3

    AST_STRAP_HOLDS: assert property (@(posedge clk) disable iff (rst)
        strap_lock |-> reg_rdata[4]); // R5

    AST_NO_REBOOT_BLOCK: assert property (@(posedge clk) disable iff (rst)
        reboot_o |-> !$past(reg_rdata[4])); // R6

    AST_S5_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        s5_rst_o |-> $past(reg_rdata[3])); // R7

    AST_PLL_FOLLOWS_PG: assert property (@(posedge clk) disable iff (rst)
        $past(cpu_pwrgood) |-> pll_en_o); // R8

endmodule

bind pmrp_ctrl pmrp_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .reg_wr       (reg_wr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .shutdown_msg (shutdown_msg),
    .init_o       (init_o),
    .plat_rst_o   (plat_rst_o),
    .reboot_o     (reboot_o),
    .s5_rst_o     (s5_rst_o),
    .cpu_pwrgood  (cpu_pwrgood),
    .pll_en_o     (pll_en_o),
    .strap_lock   (strap_lock)
);

// File: tb/sim_pmrp_ctrl.sv
module sim_pmrp_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_us = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        core_pwrok = 1'b0;
    logic        noreboot_strap = 1'b0;
    logic        shutdown_msg = 1'b0;
    logic        wdt_kick = 1'b0;
    logic        sleep_req = 1'b0;
    logic        sleep_done = 1'b0;
    logic        cpu_pwrgood = 1'b0;
    logic        init_o, plat_rst_o, smi_o, reboot_o, s5_rst_o, pll_en_o;

    always #2 clk = ~clk;

    pmrp_ctrl #(.WDT_TICKS(64), .SLEEP_TO_US(300), .PULSE_W(16)) u0 (
        .clk(clk), .rst(rst), .tick_us(tick_us), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .core_pwrok(core_pwrok),
        .noreboot_strap(noreboot_strap), .shutdown_msg(shutdown_msg),
        .wdt_kick(wdt_kick), .sleep_req(sleep_req), .sleep_done(sleep_done),
        .cpu_pwrgood(cpu_pwrgood), .init_o(init_o), .plat_rst_o(plat_rst_o),
        .smi_o(smi_o), .reboot_o(reboot_o), .s5_rst_o(s5_rst_o), .pll_en_o(pll_en_o)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit mon_on = 0;
    bit auto_kick = 1;
    int man_req = 0;
    int man_seen = 0;

    typedef enum int {EV_INIT, EV_PRST, EV_SMI, EV_REBOOT, EV_S5} ev_e;
    typedef struct { ev_e kind; string req; } exp_t;
    exp_t expq[$];

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic push(ev_e k, string req);
        exp_t e;
        e.kind = k;
        e.req  = req;
        expq.push_back(e);
    endtask

    task automatic got(ev_e k);
        exp_t e;
        if (expq.size() == 0) begin
            n_chk++;
            n_fail++;
            $display("FAIL unexpected-event actual=%0d expected=none", int'(k));
        end else begin
            e = expq.pop_front();
            chk(e.kind == k, e.req, "event kind", int'(k), int'(e.kind));
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // tick every other cycle
    initial forever begin
        @(negedge clk);
        tick_us <= ~tick_us;
    end

    // single driver of the kick input
    initial begin
        int kc = 0;
        forever begin
            @(negedge clk);
            wdt_kick <= 1'b0;
            if (man_req != man_seen) begin
                man_seen = man_req;
                wdt_kick <= 1'b1;
                kc = 0;
            end else if (auto_kick && tick_us) begin
                kc++;
                if (kc >= 20) begin
                    kc = 0;
                    wdt_kick <= 1'b1;
                end
            end
        end
    end

    // monitor: pops expected events as outputs rise
    initial begin
        logic [4:0] prev = '0;
        logic [4:0] cur;
        forever begin
            @(negedge clk);
            cur = {s5_rst_o, reboot_o, smi_o, plat_rst_o, init_o};
            if (mon_on) begin
                if (cur[0] && !prev[0]) got(EV_INIT);
                if (cur[1] && !prev[1]) got(EV_PRST);
                if (cur[2] && !prev[2]) got(EV_SMI);
                if (cur[3] && !prev[3]) got(EV_REBOOT);
                if (cur[4] && !prev[4]) got(EV_S5);
            end
            prev = cur;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
    end

    task automatic wr(logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        reg_wdata = '0;
    endtask

    task automatic wait_ticks(int n);
        repeat (2 * n) @(negedge clk);
    endtask

    task automatic kick();
        man_req++;
        repeat (2) @(negedge clk);
    endtask

    task automatic shutdown_width(bit prst, output int w);
        @(negedge clk);
        shutdown_msg = 1'b1;
        @(negedge clk);
        shutdown_msg = 1'b0;
        w = 0;
        while ((prst ? plat_rst_o : init_o) && w < 100) begin
            w++;
            @(negedge clk);
        end
    endtask

    task automatic pll_delay(logic [1:0] code, bit rewrite, logic [1:0] newc, output int c);
        wr({30'd0, code});
        @(negedge clk);
        cpu_pwrgood = 1'b1;
        repeat (3) @(negedge clk);
        chk(pll_en_o == 1'b1, "R8", "pll_en after power good", pll_en_o, 1);
        cpu_pwrgood = 1'b0;
        c = 0;
        if (rewrite) begin
            wr({30'd0, newc});
            c = 2;
        end
        while (pll_en_o && c < 30000) begin
            @(negedge clk);
            c++;
        end
    endtask

    initial begin
        int w;
        int c;
        int n;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        mon_on = 1;

        chk(reg_rdata == 32'h0, "R1", "reset word", reg_rdata, 0);
        wr(32'hFFFF_FFFF);
        chk(reg_rdata == 32'h3B, "R1", "all-ones write", reg_rdata, 32'h3B);
        wr(32'h0);
        chk(reg_rdata == 32'h0, "R5", "clear when unlocked", reg_rdata, 0);

        push(EV_INIT, "R2");
        shutdown_width(1'b0, w);
        chk(w == 16, "R2", "init width", w, 16);

        wr(32'h20);
        push(EV_PRST, "R3");
        shutdown_width(1'b1, w);
        chk(w == 16, "R3", "plat reset width", w, 16);
        chk(reg_rdata[5] == 1'b0, "R3", "policy bit after reset", reg_rdata[5], 0);

        noreboot_strap = 1'b1;
        core_pwrok = 1'b1;
        repeat (3) @(negedge clk);
        chk(reg_rdata[4] == 1'b1, "R4", "strap high sampled", reg_rdata[4], 1);
        wr(32'h0);
        chk(reg_rdata == 32'h10, "R5", "locked bit survives write", reg_rdata, 32'h10);

        auto_kick = 0;
        kick();
        push(EV_SMI, "R6");
        wait_ticks(150);
        chk(expq.size() == 0, "R6", "no reboot under lock", expq.size(), 0);
        auto_kick = 1;
        kick();

        core_pwrok = 1'b0;
        noreboot_strap = 1'b0;
        repeat (3) @(negedge clk);
        core_pwrok = 1'b1;
        repeat (3) @(negedge clk);
        chk(reg_rdata[4] == 1'b0, "R4", "strap low sampled", reg_rdata[4], 0);
        wr(32'h10);
        chk(reg_rdata == 32'h10, "R5", "set when unlocked", reg_rdata, 32'h10);
        wr(32'h0);
        chk(reg_rdata == 32'h0, "R5", "clear when unlocked", reg_rdata, 0);

        auto_kick = 0;
        kick();
        push(EV_SMI, "R6");
        push(EV_REBOOT, "R6");
        wait_ticks(150);
        kick();
        chk(expq.size() == 0, "R6", "smi then reboot seen", expq.size(), 0);
        push(EV_SMI, "R6");
        wait_ticks(70);
        kick();
        push(EV_SMI, "R6");
        wait_ticks(70);
        auto_kick = 1;
        kick();
        chk(expq.size() == 0, "R6", "kick forgets first expiry", expq.size(), 0);

        wr(32'h08);
        push(EV_S5, "R7");
        @(negedge clk); sleep_req = 1'b1;
        @(negedge clk); sleep_req = 1'b0;
        wait_ticks(400);
        chk(expq.size() == 0, "R7", "timeout fired", expq.size(), 0);
        @(negedge clk); sleep_req = 1'b1;
        @(negedge clk); sleep_req = 1'b0;
        wait_ticks(100);
        sleep_done = 1'b1;
        @(negedge clk); sleep_done = 1'b0;
        wait_ticks(400);
        chk(s5_rst_o == 1'b0, "R7", "done before timeout", s5_rst_o, 0);
        wr(32'h0);
        @(negedge clk); sleep_req = 1'b1;
        @(negedge clk); sleep_req = 1'b0;
        wait_ticks(400);
        chk(s5_rst_o == 1'b0, "R7", "timeout disabled", s5_rst_o, 0);
        sleep_done = 1'b1;
        @(negedge clk); sleep_done = 1'b0;

        for (int k = 0; k < 4; k++) begin
            n = (k == 0) ? 10 : (k == 1) ? 100 : (k == 2) ? 1000 : 10000;
            pll_delay(2'(k), 1'b0, 2'b00, c);
            chk(c >= 2 * n - 1 && c <= 2 * n + 2, "R8", "pll hold cycles", c, 2 * n);
        end
        pll_delay(2'b01, 1'b1, 2'b00, c);
        chk(c >= 199 && c <= 202, "R9", "delay kept after rewrite", c, 200);

        wait_ticks(5);
        chk(expq.size() == 0, "R2", "all expected events seen", expq.size(), 0);
        summary();
    end

endmodule